// File: doc/BRIEF.md
# Serial Two's-Complement Adder/Subtractor

This block combines two operand streams one bit per clock, least significant bit first, and returns the result stream in the same cycle as the operand bits that form it. A word is 32 bits long. The sign bit comes last and carries weight -1, so each word is a signed fraction from -1 up to, but not including, +1. A strobe marks the last bit of each word. One flip-flop holds the carry (or the borrow) from one bit to the next, and the strobe clears it, so the next word starts clean.

A select input chooses between the sum and the difference. The difference is first operand minus second operand. The sum output is always the three-way XOR of the two operand bits and the stored carry. For subtraction only the carry network changes: it sees the first operand inverted. When the true result falls outside the fraction range, an overflow pulse rises during the strobe cycle. The select should be held steady across a word.

Top module: `serial_addsub`

## Requirements
- R1: `res_bit` equals `op_i ^ op_j ^ carry` in the same cycle as the operand bits, where carry is the stored carry or borrow from the previous bit of the word.
- R2: With `sub_sel`=0, the stored carry becomes 1 after a cycle in which both operand bits are 1. It becomes 0 after a cycle in which both are 0. Otherwise it keeps its value.
- R3: With `sub_sel`=1, the carry rules of R2 apply with `op_i` inverted, so that a 32-bit word yields first operand minus second operand, modulo 2^32.
- R4: After any cycle with `word_end`=1, the stored carry is 0, whatever the operand bits in that cycle. This also holds when a word is cut short.
- R5: While `rst_n` is low, the stored carry clears, and it is 0 on the first bit after reset.
- R6: In the `word_end` cycle, `ovf_pulse` is 1 exactly when the signed sum or difference of the two 32-bit words lies outside [-2^31, 2^31-1], taken as integers. Equivalently, the carry into the sign bit differs from the carry out of it.
- R7: `ovf_pulse` is 0 in every cycle where `word_end` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset, clears the carry |
| op_i | input | 1 | First operand bit (minuend when subtracting) |
| op_j | input | 1 | Second operand bit (subtrahend when subtracting) |
| sub_sel | input | 1 | 0 selects add, 1 selects op_i minus op_j |
| word_end | input | 1 | High during the sign (last) bit of a word |
| res_bit | output | 1 | Result bit for the current position |
| ovf_pulse | output | 1 | One-cycle overflow flag in the word_end cycle |

## Verification
If the carry flip-flop held a wrong value, `res_bit` would be inverted at the very next bit position, one clock later. From there the error would spread into the rest of that word's result. It could also make `ovf_pulse` wrong at the word's end. A carry that failed to clear at the word boundary would show as an inverted first bit of the following word. The bench therefore checks full words against an integer model and also the first bit after each boundary and after reset.

// File: rtl/serial_addsub.sv
module serial_addsub (
  input  logic clk,
  input  logic rst_n,
  input  logic op_i,
  input  logic op_j,
  input  logic sub_sel,
  input  logic word_end,
  output logic res_bit,
  output logic ovf_pulse
);

  logic carry_q;
  logic i_eff;
  logic carry_nx;

  // carry path sees op_i inverted when subtracting; sum path never does
  assign i_eff    = op_i ^ sub_sel;
  assign carry_nx = (i_eff & op_j) | (carry_q & (i_eff ^ op_j));

  assign res_bit   = op_i ^ op_j ^ carry_q;
  assign ovf_pulse = word_end & (carry_nx ^ carry_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      carry_q <= 1'b0;
    else if (word_end)
      carry_q <= 1'b0;
    else
      carry_q <= carry_nx;
  end

  // R4
  boundary_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> (res_bit == (op_i ^ op_j)));

  // R7
  ovf_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> word_end);

  // R2
  add_generate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_end && !sub_sel && op_i && op_j) |=> (res_bit == !(op_i ^ op_j)));

  // R2
  add_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_end && !sub_sel && !op_i && !op_j) |=> (res_bit == (op_i ^ op_j)));

  // R3
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_end && sub_sel && !op_i && op_j) |=> (res_bit == !(op_i ^ op_j)));

  // R3
  sub_noborrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_end && sub_sel && op_i && !op_j) |=> (res_bit == (op_i ^ op_j)));

endmodule

// File: tb/tb_serial_addsub.sv
module tb_serial_addsub;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_i = 1'b0;
  logic op_j = 1'b0;
  logic sub_sel = 1'b0;
  logic word_end = 1'b0;
  logic res_bit;
  logic ovf_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_addsub dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .op_j(op_j),
    .sub_sel(sub_sel), .word_end(word_end),
    .res_bit(res_bit), .ovf_pulse(ovf_pulse)
  );

  localparam int NV = 14;
  // {sub, a, b}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 32'h1234_5678, 32'h0F0F_0F0F},
    {1'b0, 32'h4000_0000, 32'h4000_0000},
    {1'b0, 32'h7FFF_FFFF, 32'h0000_0001},
    {1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b0, 32'h8000_0000, 32'h8000_0000},
    {1'b0, 32'h8000_0000, 32'h7FFF_FFFF},
    {1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 32'h0000_0005, 32'h0000_0007},
    {1'b1, 32'h0000_0000, 32'h8000_0000},
    {1'b1, 32'h8000_0000, 32'h0000_0001},
    {1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {1'b1, 32'hC000_0000, 32'h4000_0000}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_word(input logic s, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] got;
    logic ov_end;
    logic ov_early;
    logic [32:0] full;
    ov_early = 1'b0;
    ov_end = 1'b0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      op_i = a[k]; op_j = b[k]; sub_sel = s; word_end = (k == 31);
      #1;
      got[k] = res_bit;
      if (k == 31) ov_end = ovf_pulse;
      else if (ovf_pulse) ov_early = 1'b1;
    end
    @(negedge clk);
    word_end = 1'b0; op_i = 1'b0; op_j = 1'b0;
    full = s ? ({a[31], a} - {b[31], b}) : ({a[31], a} + {b[31], b});
    check(s ? "R3" : "R1", "word result", got, full[31:0]);
    check("R6", "overflow at word end", {31'd0, ov_end}, {31'd0, full[32] ^ full[31]});
    check("R7", "overflow before word end", {31'd0, ov_early}, 32'd0);
  endtask

  task automatic drive_bit(input logic s, input logic a, input logic b, input logic e);
    @(negedge clk);
    op_i = a; op_j = b; sub_sel = s; word_end = e;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state: no carry on first bit
    drive_bit(1'b0, 1'b1, 1'b1, 1'b0);
    check("R5", "first bit after reset", {31'd0, res_bit}, 32'd0);
    check("R7", "no overflow mid word", {31'd0, ovf_pulse}, 32'd0);
    // R2 hold: carry set above, differing bits keep it
    drive_bit(1'b0, 1'b1, 1'b0, 1'b0);
    check("R2", "carry propagates", {31'd0, res_bit}, 32'd0);
    drive_bit(1'b0, 1'b0, 1'b0, 1'b0);
    check("R2", "carry held then used", {31'd0, res_bit}, 32'd1);
    drive_bit(1'b0, 1'b0, 1'b0, 1'b0);
    check("R2", "carry killed", {31'd0, res_bit}, 32'd0);

    // R4 truncated word: generate carry on a word_end cycle
    drive_bit(1'b0, 1'b1, 1'b1, 1'b1);
    drive_bit(1'b0, 1'b0, 1'b0, 1'b0);
    check("R4", "carry cleared at short word end", {31'd0, res_bit}, 32'd0);

    // R3 borrow generate then consume
    drive_bit(1'b1, 1'b0, 1'b1, 1'b0);
    check("R3", "difference bit 0-1", {31'd0, res_bit}, 32'd1);
    drive_bit(1'b1, 1'b0, 1'b0, 1'b0);
    check("R3", "borrow applied", {31'd0, res_bit}, 32'd1);
    // R4 borrow pending at word end is dropped
    drive_bit(1'b1, 1'b0, 1'b1, 1'b1);
    drive_bit(1'b1, 1'b1, 1'b0, 1'b0);
    check("R4", "borrow cleared at word end", {31'd0, res_bit}, 32'd1);
    drive_bit(1'b0, 1'b0, 1'b0, 1'b1);

    // R5 reset mid word with carry pending
    drive_bit(1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    op_i = 1'b0; op_j = 1'b0; word_end = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive_bit(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5", "carry cleared by reset", {31'd0, res_bit}, 32'd0);
    drive_bit(1'b0, 1'b0, 1'b0, 1'b1);

    for (int v = 0; v < NV; v++)
      run_word(VEC[v][64], VEC[v][63:32], VEC[v][31:0]);

    for (int r = 0; r < 40; r++)
      run_word(r[0], $urandom, $urandom);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule